// File: doc/BRIEF.md
# SMP Miscellaneous Control Register

This block is one 64-bit control and status word shared by the four processors of a small multiprocessor. It holds three kinds of state. The first is a pending interval-timer flag for each processor. The second is a pending interprocessor-interrupt flag for each processor. The third is a pair of bus-arbitration fields, one recording arbitration attempts and one recording which agent won. The word also holds a sticky fault flag and a four-bit field for software to read and write. The timer flags and the interprocessor flags are also the block's interrupt outputs: one line of each kind per processor.

Software reaches the register through a plain single-cycle write strobe carrying the full 64-bit value. Different bit groups react differently to a write:

- Flags are cleared by writing ones.
- A second group of bits acts as send requests: a one posts an interprocessor interrupt to the matching processor.
- The attempt field accumulates ones.
- The winner field only latches while it is empty.
- A single flush bit wipes both arbitration fields.

Per-processor timer pulses and a fault pulse set their flags directly. The read value is combinational. It carries the index of the processor doing the read in its two lowest bits, so one shared register lets each processor learn its own identity.

Top module: `smp_misc_reg`

## Requirements
- R1: A cycle with `rst` high clears every stored bit. Afterwards `ipi_irq` and `timer_irq` are zero, and `rd_data` bits 63..2 read zero.
- R2: A high bit i of `tick_set` sets timer flag bit 4+i at the next clock edge. `timer_irq[i]` always equals that bit, and only a tick can raise it.
- R3: A write with data bit 4+i at one clears timer flag i. A tick in the same cycle overrides the clear, so the flag stays set.
- R4: A write with data bit 12+i at one sets interprocessor flag bit 8+i. `ipi_irq[i]` equals that bit, and only such a write can raise it.
- R5: A write with data bit 8+i at one clears interprocessor flag i. If the same write also carries request bit 12+i, the flag ends up set.
- R6: A write with data bit 20 at one clears both arbitration fields (bits 23..16), and that write sets none of those bits.
- R7: A write with data bit 20 at zero ORs data bits 23..20 into the attempt field, bits 23..20.
- R8: A write with data bit 20 at zero loads data bits 19..16 into the winner field, bits 19..16, only if that field holds zero before the write. Otherwise the winner field keeps its value.
- R9: Every write replaces bits 43..40 with data bits 43..40.
- R10: `rd_data` bits 1..0 always equal `rd_cpu`.
- R11: Bits 3..2, 27..24, 39..29 and 63..44 read zero, and writing ones to them changes no state.
- R12: A `fault_set` pulse sets bit 28. A write with data bit 28 at one clears it, but a pulse in the same cycle overrides that clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 64 | Write value |
| tick_set | input | 4 | Per-processor interval timer event pulses |
| fault_set | input | 1 | Fault event pulse for bit 28 |
| rd_cpu | input | 2 | Index of the processor performing the read |
| rd_data | output | 64 | Register value with the reader index in bits 1..0 |
| ipi_irq | output | 4 | Interprocessor interrupt line per processor |
| timer_irq | output | 4 | Interval timer interrupt line per processor |

## Verification
The hardest situations to reach from the ports are collisions inside one cycle. These are a tick arriving on the same edge as a write that clears its flag, a send request paired with a clear of the same interprocessor flag, and a fault pulse meeting its own clear. The stimulus drives each pair of inputs together on one falling edge, so that both land on the same rising edge. The winner field's load-only-when-empty rule needs a history of writes. The sequence therefore loads the field, tries to overwrite it while it is non-empty, flushes it, and then loads it again.

// File: rtl/smp_misc_pkg.sv
`timescale 1ns/1ps
package smp_misc_pkg;
    localparam int NCPU     = 4;
    localparam int DW       = 64;
    localparam int CPU_IDW  = $clog2(NCPU);
    localparam int ARB_W    = 4;
    localparam int USR_W    = 4;

    // Bit positions that define software-visible behaviour
    localparam int TMR_LSB   = 4;
    localparam int IPI_LSB   = TMR_LSB + NCPU;
    localparam int REQ_LSB   = IPI_LSB + NCPU;
    localparam int WON_LSB   = 16;
    localparam int TRY_LSB   = WON_LSB + ARB_W;
    localparam int FLUSH_BIT = 20;
    localparam int FLUSH_IDX = FLUSH_BIT - TRY_LSB;
    localparam int FAULT_BIT = 28;
    localparam int USR_LSB   = 40;

    typedef struct packed {
        logic [USR_W-1:0] usr;
        logic             fault;
        logic [ARB_W-1:0] try_f;
        logic [ARB_W-1:0] won;
        logic [NCPU-1:0]  ipi;
        logic [NCPU-1:0]  tmr;
    } misc_state_t;

    function automatic logic [DW-1:0] pack_state(input misc_state_t s);
        logic [DW-1:0] r;
        r = '0;
        r[TMR_LSB +: NCPU]  = s.tmr;
        r[IPI_LSB +: NCPU]  = s.ipi;
        r[WON_LSB +: ARB_W] = s.won;
        r[TRY_LSB +: ARB_W] = s.try_f;
        r[FAULT_BIT]        = s.fault;
        r[USR_LSB +: USR_W] = s.usr;
        return r;
    endfunction

    function automatic logic [DW-1:0] live_mask();
        misc_state_t all;
        all = '1;
        return pack_state(all);
    endfunction
endpackage

// File: rtl/smp_flag_vec.sv
`timescale 1ns/1ps
// Set-dominant flag group: a set event overrides a clear in the same cycle.
module smp_flag_vec #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/smp_arb_field.sv
`timescale 1ns/1ps
// Arbitration attempt / winner pair with flush control.
module smp_arb_field #(
    parameter int W       = 4,
    parameter int FLUSH_I = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_try,
    input  logic [W-1:0] wr_won,
    output logic [W-1:0] try_q,
    output logic [W-1:0] won_q
);
    logic flush;
    logic won_empty;

    assign flush     = wr_try[FLUSH_I];
    assign won_empty = (won_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            try_q <= '0;
            won_q <= '0;
        end else if (wr_en) begin
            if (flush) begin
                try_q <= '0;
                won_q <= '0;
            end else begin
                try_q <= try_q | wr_try;
                if (won_empty) won_q <= wr_won;
            end
        end
    end
endmodule

// File: rtl/smp_misc_readback.sv
`timescale 1ns/1ps
module smp_misc_readback
    import smp_misc_pkg::*;
(
    input  misc_state_t        st,
    input  logic [CPU_IDW-1:0] rd_cpu,
    output logic [DW-1:0]      rd_data
);
    always_comb begin
        rd_data = pack_state(st);
        rd_data[CPU_IDW-1:0] = rd_cpu;
    end
endmodule

// File: rtl/smp_misc_reg.sv
`timescale 1ns/1ps
module smp_misc_reg
    import smp_misc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic [NCPU-1:0]    tick_set,
    input  logic               fault_set,
    input  logic [CPU_IDW-1:0] rd_cpu,
    output logic [DW-1:0]      rd_data,
    output logic [NCPU-1:0]    ipi_irq,
    output logic [NCPU-1:0]    timer_irq
);
    misc_state_t      st;
    logic [USR_W-1:0] usr_q;
    logic             fault_q;
    logic [ARB_W-1:0] try_q;
    logic [ARB_W-1:0] won_q;

    // Per-processor interrupt flags: {ipi, timer}
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [1:0] set_v;
        logic [1:0] clr_v;
        logic [1:0] q_v;

        assign set_v = {wr_en & wr_data[REQ_LSB + c], tick_set[c]};
        assign clr_v = {wr_en & wr_data[IPI_LSB + c], wr_en & wr_data[TMR_LSB + c]};

        smp_flag_vec #(.W(2)) u_flags (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v),
            .clr_i (clr_v),
            .q_o   (q_v)
        );

        assign ipi_irq[c]   = q_v[1];
        assign timer_irq[c] = q_v[0];
    end

    smp_flag_vec #(.W(1)) u_fault (
        .clk   (clk),
        .rst   (rst),
        .set_i (fault_set),
        .clr_i (wr_en & wr_data[FAULT_BIT]),
        .q_o   (fault_q)
    );

    smp_arb_field #(.W(ARB_W), .FLUSH_I(FLUSH_IDX)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_try (wr_data[TRY_LSB +: ARB_W]),
        .wr_won (wr_data[WON_LSB +: ARB_W]),
        .try_q  (try_q),
        .won_q  (won_q)
    );

    always_ff @(posedge clk) begin
        if (rst)        usr_q <= '0;
        else if (wr_en) usr_q <= wr_data[USR_LSB +: USR_W];
    end

    always_comb begin
        st       = '0;
        st.tmr   = timer_irq;
        st.ipi   = ipi_irq;
        st.won   = won_q;
        st.try_f = try_q;
        st.fault = fault_q;
        st.usr   = usr_q;
    end

    smp_misc_readback u_rb (
        .st      (st),
        .rd_cpu  (rd_cpu),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/smp_misc_chk.sv
`timescale 1ns/1ps
module smp_misc_chk
    import smp_misc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [DW-1:0]      wr_data,
    input logic [NCPU-1:0]    tick_set,
    input logic [CPU_IDW-1:0] rd_cpu,
    input logic [DW-1:0]      rd_data,
    input logic [NCPU-1:0]    ipi_irq,
    input logic [NCPU-1:0]    timer_irq
);
    localparam logic [DW-1:0] DEAD = ~(live_mask() | {{(DW-CPU_IDW){1'b0}}, {CPU_IDW{1'b1}}});

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data[DW-1:CPU_IDW] == '0 && ipi_irq == '0 && timer_irq == '0));

    // R2
    tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|tick_set) |=> ((timer_irq & $past(tick_set)) == $past(tick_set)));

    // R2
    tmr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((timer_irq & ~$past(timer_irq) & ~$past(tick_set)) == '0));

    // R4
    ipi_rise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ipi_irq & ~$past(ipi_irq) &
                   ~($past(wr_en) ? $past(wr_data[REQ_LSB +: NCPU]) : '0)) == '0));

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[FLUSH_BIT]) |=> (rd_data[WON_LSB +: 2*ARB_W] == '0));

    // R9
    usr_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[USR_LSB +: USR_W] == $past(wr_data[USR_LSB +: USR_W])));

    // R10
    cpu_id_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[CPU_IDW-1:0] == rd_cpu);

    // R11
    dead_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & DEAD) == '0);
endmodule

bind smp_misc_reg smp_misc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tick_set  (tick_set),
    .rd_cpu    (rd_cpu),
    .rd_data   (rd_data),
    .ipi_irq   (ipi_irq),
    .timer_irq (timer_irq)
);

// File: tb/tb_smp_misc_reg.sv
`timescale 1ns/1ps
module tb_smp_misc_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [3:0]  tick_set = '0;
    logic        fault_set = 1'b0;
    logic [1:0]  rd_cpu = '0;
    logic [63:0] rd_data;
    logic [3:0]  ipi_irq;
    logic [3:0]  timer_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic [63:0] rd;
        logic [3:0]  ipi;
        logic [3:0]  tmr;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] model = '0;
    logic [1:0]  cpu_rr = '0;

    always #10 clk = ~clk;

    smp_misc_reg dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tick_set  (tick_set),
        .fault_set (fault_set),
        .rd_cpu    (rd_cpu),
        .rd_data   (rd_data),
        .ipi_irq   (ipi_irq),
        .timer_irq (timer_irq)
    );

    task automatic compare(input string tag, input logic [63:0] a_rd, input logic [63:0] e_rd,
                           input logic [3:0] a_i, input logic [3:0] e_i,
                           input logic [3:0] a_t, input logic [3:0] e_t);
        checks++;
        if (a_rd !== e_rd || a_i !== e_i || a_t !== e_t) begin
            failures++;
            $display("FAIL %s: rd=%h ipi=%b tmr=%b expected rd=%h ipi=%b tmr=%b",
                     tag, a_rd, a_i, a_t, e_rd, e_i, e_t);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(input string tag, input logic we, input logic [63:0] w,
                        input logic [3:0] tk, input logic ft);
        logic [63:0] n;
        exp_t        e;
        @(negedge clk);
        wr_en = we; wr_data = w; tick_set = tk; fault_set = ft;
        rd_cpu = cpu_rr;
        n = model;
        if (we) begin
            n = n & ~(w & 64'h0000_0000_1000_0FF0);
            if (w[20]) n[23:16] = 8'h00;
            else begin
                n[23:20] = n[23:20] | w[23:20];
                if (n[19:16] == 4'h0) n[19:16] = w[19:16];
            end
            n[11:8]  = n[11:8] | w[15:12];
            n[43:40] = w[43:40];
        end
        n[7:4] = n[7:4] | tk;
        n[28]  = n[28] | ft;
        model  = n;
        e.tag = tag; e.rd = n | {62'd0, cpu_rr};
        e.ipi = n[11:8]; e.tmr = n[7:4];
        sb.push_back(e);
        cpu_rr = cpu_rr + 2'd1;
    endtask

    // Monitor: compare after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.tag, rd_data, e.rd, ipi_irq, e.ipi, timer_irq, e.tmr);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_cpu = 2'd2;
        #1;
        compare("R1 reset state", rd_data, 64'h2, ipi_irq, 4'h0, timer_irq, 4'h0);

        step("R2 ticks cpu0 cpu2", 1'b0, 64'h0, 4'b0101, 1'b0);
        step("R3 tick beats clear", 1'b1, 64'h10, 4'b0001, 1'b0);
        step("R3 w1c timer flags", 1'b1, 64'h50, 4'b0000, 1'b0);
        step("R2 tick cpu3 idle write", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000, 1'b0);
        step("R4 ipi requests", 1'b1, 64'hA000, 4'b0000, 1'b0);
        step("R5 request beats clear", 1'b1, 64'h2A00, 4'b0000, 1'b0);
        step("R7 R8 try and won load", 1'b1, 64'h00E5_0000, 4'b0000, 1'b0);
        step("R8 won held nonzero", 1'b1, 64'h000A_0000, 4'b0000, 1'b0);
        step("R6 flush arbitration", 1'b1, 64'h001F_0000, 4'b0000, 1'b0);
        step("R8 won reload after flush", 1'b1, 64'h0003_0000, 4'b0000, 1'b0);
        step("R9 rw field A", 1'b1, 64'h0000_0A00_0000_0000, 4'b0000, 1'b0);
        step("R9 rw field 5", 1'b1, 64'h0000_0500_0000_0000, 4'b0000, 1'b0);
        step("R11 dead bits ignored", 1'b1,
             ~64'h0000_0F00_10FF_FFF0 | 64'h0000_0500_0000_0000, 4'b0000, 1'b0);
        step("R12 fault set", 1'b0, 64'h0, 4'b0000, 1'b1);
        step("R12 fault beats clear", 1'b1, 64'h0000_0500_1000_0000, 4'b0000, 1'b1);
        step("R12 fault w1c", 1'b1, 64'h0000_0500_1000_0000, 4'b0000, 1'b0);
        step("R10 reader id", 1'b0, 64'h0, 4'b0000, 1'b0);
        step("R5 ipi w1c all", 1'b1, 64'h0000_0500_0000_0F00, 4'b0000, 1'b0);

        @(negedge clk);
        wr_en = 1'b0; tick_set = '0; fault_set = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset mid-run clears populated state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_cpu = 2'd1;
        #1;
        compare("R1 reset after traffic", rd_data, 64'h1, ipi_irq, 4'h0, timer_irq, 4'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule